// File: doc/BRIEF.md
# Double-Buffered Pulse-Width Modulator

This block produces one pulse-width modulated output from a free-running counter. The counter advances only on cycles where a PWM clock enable is high. Software places a period value and a pulse width value in two staging registers through a small write/read port, and it may do so at any time. The hardware copies both staged values into hidden active registers when the current period ends. A load strobe makes the copy happen at once and starts a fresh period. Only the active values drive the counter wrap and the pulse comparator, so a staged value never disturbs the pulse that is being generated.

In each period the output goes high at the first count and drops when the counter reaches the active pulse width. A pulse width of zero holds the output low without a glitch. A pulse width at or above the active period holds it high without a glitch. A period value of zero selects the longest period of 65536 enable ticks. In that mode the output is high for at most 65535 ticks.

Top module: `pwm_dbuf`

## Requirements
- R1: Reset is synchronous and active high. After reset the output is low, both staging registers read back as zero, and the output stays low while ticks arrive, because the active width is zero.
- R2: A write with `wr_sel`=0 sets the staging period and a write with `wr_sel`=1 sets the staging width. `rd_data` shows the staging register picked by `rd_sel` (same encoding) one clock after the selection. The hardware never changes a staging register.
- R3: A staged value that is written without a load does not change the current period. It takes effect from the next period boundary on.
- R4: The counter and the output change only on cycles where `pwm_tick` is high, or on a load strobe. With `pwm_tick` low and no load, both hold their values.
- R5: With active period P (1..65535) and active width W, the counter runs through 0..P-1 on ticks and then wraps. The output is high for counts below W and low from the count equal to W until the wrap.
- R6: An active width of 0 gives a constant low output, including across period boundaries.
- R7: An active width greater than or equal to a nonzero active period gives a constant high output, with no low cycle at any boundary.
- R8: An active period of 0 gives a period of 65536 ticks. With width 0xFFFF the output is high for 65535 ticks and low for 1 tick.
- R9: A load strobe copies both staging registers to the active registers on that clock, whatever the state of `pwm_tick`. It restarts the counter at 0 and sets the output high unless the new width is 0.
- R10: Period 2 with width 1 gives the fastest waveform: the output toggles on every tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_tick | input | 1 | PWM clock enable; the counter advances when high |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_sel | input | 1 | Write target: 0 period, 1 width |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Readback select: 0 period, 1 width |
| rd_data | output | 16 | Registered readback of the selected staging register |
| load | input | 1 | Forced load: copy staged values and restart the period |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions assume that every input is steady around the rising edge. They place no limit on the pattern of `pwm_tick` or on when a load may arrive, so they must hold when a load lands in the middle of a period or on a cycle with no tick. The bench changes every input only on the falling edge. It never issues a load in the same cycle as a write, so the staged value that a load picks up is always clear. It keeps `pwm_tick` high except for one window in which the enable is held low and a second window in which a load is given without a tick.

// File: rtl/pwm_dbuf_pkg.sv
`timescale 1ns/1ps
package pwm_dbuf_pkg;
  // default counter and register width
  localparam int PWM_CW = 16;

  // staging register select encoding, shared by write and readback
  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_WIDTH  = 1'b1
  } pwm_reg_e;

  localparam int PWM_NREG = 2;
endpackage

// File: rtl/pwm_stage.sv
`timescale 1ns/1ps
module pwm_stage
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = PWM_CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [CW-1:0] rd_data,
  output logic [CW-1:0] stg_per,
  output logic [CW-1:0] stg_wid
);
  // software-owned staging registers; the hardware only reads them
  logic [CW-1:0] stg_q [PWM_NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PWM_NREG; i++) stg_q[i] <= '0;
    end else if (wr_en) begin
      stg_q[wr_sel] <= wr_data;
    end
  end

  // registered readback, one clock of latency
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= stg_q[rd_sel];
  end

  assign stg_per = stg_q[int'(SEL_PERIOD)];
  assign stg_wid = stg_q[int'(SEL_WIDTH)];
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = PWM_CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] stg_per,
  input  logic [CW-1:0] stg_wid,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic [CW-1:0] act_per,
  output logic [CW-1:0] act_wid,
  output logic          restart
);
  localparam logic [CW-1:0] ONE = CW'(1);

  // last count of the period; a period of 0 wraps to all ones, i.e. 2**CW ticks
  logic [CW-1:0] per_last;
  logic          at_last;

  assign per_last = act_per - ONE;
  assign at_last  = (cnt == per_last);
  assign restart  = load | (tick & at_last);
  assign cnt_nxt  = cnt + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_per <= '0;
      act_wid <= '0;
    end else if (restart) begin
      cnt     <= '0;
      act_per <= stg_per;
      act_wid <= stg_wid;
    end else if (tick) begin
      cnt     <= cnt_nxt;
    end
  end
endmodule

// File: rtl/pwm_outflop.sv
`timescale 1ns/1ps
module pwm_outflop
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = PWM_CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] stg_wid,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] act_wid,
  output logic          pwm_out
);
  // equality against the count being entered, so the registered output
  // lines up with the counter value it belongs to
  logic hit;

  assign hit = tick & (cnt_nxt == act_wid);

  always_ff @(posedge clk) begin
    if (rst)          pwm_out <= 1'b0;
    else if (restart) pwm_out <= |stg_wid;
    else if (hit)     pwm_out <= 1'b0;
  end
endmodule

// File: rtl/pwm_dbuf.sv
`timescale 1ns/1ps
module pwm_dbuf
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = PWM_CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwm_tick,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [CW-1:0] rd_data,
  input  logic          load,
  output logic          pwm_out
);
  logic [CW-1:0] stg_per;
  logic [CW-1:0] stg_wid;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] act_per;
  logic [CW-1:0] act_wid;
  logic          restart;

  pwm_stage #(.CW(CW)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .stg_per (stg_per),
    .stg_wid (stg_wid)
  );

  pwm_timebase #(.CW(CW)) u_tb (
    .clk     (clk),
    .rst     (rst),
    .tick    (pwm_tick),
    .load    (load),
    .stg_per (stg_per),
    .stg_wid (stg_wid),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .act_per (act_per),
    .act_wid (act_wid),
    .restart (restart)
  );

  pwm_outflop #(.CW(CW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .tick    (pwm_tick),
    .restart (restart),
    .stg_wid (stg_wid),
    .cnt_nxt (cnt_nxt),
    .act_wid (act_wid),
    .pwm_out (pwm_out)
  );
endmodule

// File: rtl/pwm_dbuf_chk.sv
`timescale 1ns/1ps
module pwm_dbuf_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          pwm_tick,
  input logic          load,
  input logic          pwm_out,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] act_per,
  input logic [CW-1:0] act_wid
);
  AST_RESET_LOW: assert property (@(posedge clk) rst |=> !pwm_out); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pwm_tick && !load) |=> ($stable(pwm_out) && $stable(cnt))); // R4

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (act_per != '0) |-> (cnt < act_per)); // R5

  AST_FALL_AT_MATCH: assert property (@(posedge clk) disable iff (rst)
    $fell(pwm_out) |-> (cnt == act_wid)); // R5

  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
    (act_wid == '0) |-> !pwm_out); // R6

  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
    ((act_per != '0) && (act_wid >= act_per)) |-> pwm_out); // R7

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == '0)); // R9
endmodule

bind pwm_dbuf pwm_dbuf_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwm_tick (pwm_tick),
  .load     (load),
  .pwm_out  (pwm_out),
  .cnt      (cnt),
  .act_per  (act_per),
  .act_wid  (act_wid)
);

// File: tb/pwm_dbuf_test.sv
`timescale 1ns/1ps
module pwm_dbuf_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwm_tick = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic        load = 1'b0;
  logic        pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwm_dbuf uut (
    .clk(clk), .rst(rst), .pwm_tick(pwm_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .load(load), .pwm_out(pwm_out)
  );

  // {period, width, samples}
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {16'd10, 16'd3, 16'd30},
    {16'd7,  16'd6, 16'd21},
    {16'd4,  16'd1, 16'd12},
    {16'd5,  16'd0, 16'd15},
    {16'd5,  16'd5, 16'd15},
    {16'd5,  16'd9, 16'd15},
    {16'd1,  16'd1, 16'd6},
    {16'd2,  16'd1, 16'd10}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected output at sample k after a restart (sample 0 = right after it)
  function automatic logic model(int k, int p, int w);
    int pe;
    pe = (p == 0) ? 65536 : p;
    if (w == 0) return 1'b0;
    return ((k % pe) < w);
  endfunction

  task automatic wr(logic sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // starts at sample 0 (current negedge)
  task automatic run_cmp(int p, int w, int n, string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      if (pwm_out !== model(k, p, w)) bad++;
    end
    check(req, bad, 0);
  endtask

  task automatic readback(logic sel, logic [15:0] exp, string req);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, no requirement reached its end");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int p, w, n, bad, highs;
    string vreq;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 out after reset", pwm_out, 0);
    check("R1 staged period reads zero", rd_data, 0);
    readback(1'b1, 16'h0000, "R1 staged width reads zero");
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwm_out !== 1'b0) bad++;
    end
    check("R1 output low with ticks", bad, 0);

    // R2: staging write and readback
    wr(1'b0, 16'h1234);
    wr(1'b1, 16'h0042);
    readback(1'b0, 16'h1234, "R2 period readback");
    readback(1'b1, 16'h0042, "R2 width readback");

    // table of waveforms, each started with a forced load
    for (int v = 0; v < NV; v++) begin
      p = int'(VEC[v][47:32]);
      w = int'(VEC[v][31:16]);
      n = int'(VEC[v][15:0]);
      if (w == 0)      vreq = "R6 constant low";
      else if (w >= p) vreq = "R7 constant high";
      else if (p == 2) vreq = "R10 fastest toggle";
      else             vreq = "R5 waveform";
      wr(1'b0, 16'(p));
      wr(1'b1, 16'(w));
      pulse_load();
      run_cmp(p, w, n, vreq);
    end

    // R3: staged width without load waits for the boundary
    wr(1'b0, 16'd8);
    wr(1'b1, 16'd2);
    pulse_load();
    bad = 0;
    for (int k = 0; k < 24; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 1) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'd6; end
      if (k == 2) wr_en = 1'b0;
      if (pwm_out !== model(k, 8, (k < 8) ? 2 : 6)) bad++;
    end
    check("R3 double buffer boundary", bad, 0);

    // R4: enable low freezes counter and output
    wr(1'b0, 16'd4);
    wr(1'b1, 16'd2);
    pulse_load();
    pwm_tick = 1'b0;
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (pwm_out !== 1'b1) bad++;
    end
    check("R4 hold without tick", bad, 0);
    pwm_tick = 1'b1;
    bad = 0;
    for (int k = 1; k < 12; k++) begin
      @(negedge clk);
      if (pwm_out !== model(k, 4, 2)) bad++;
    end
    check("R4 resume after tick", bad, 0);

    // R9: forced load in mid-period restarts with the new width
    wr(1'b0, 16'd10);
    wr(1'b1, 16'd8);
    pulse_load();
    bad = 0;
    for (int k = 0; k < 26; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 3) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'd1; end
      if (k == 4) wr_en = 1'b0;
      if (k == 5) load = 1'b1;
      if (k == 6) load = 1'b0;
      if (pwm_out !== ((k < 6) ? model(k, 10, 8) : model(k - 6, 10, 1))) bad++;
    end
    check("R9 mid-period restart", bad, 0);

    // R6 then R9 with no tick
    wr(1'b0, 16'd6);
    wr(1'b1, 16'd0);
    pulse_load();
    check("R6 zero width low after load", pwm_out, 0);
    pwm_tick = 1'b0;
    wr(1'b1, 16'd3);
    check("R3 staged width alone leaves output", pwm_out, 0);
    pulse_load();
    check("R9 load without tick sets output", pwm_out, 1);
    pwm_tick = 1'b1;

    // R8: period 0 means 65536 ticks, width 0xFFFF
    wr(1'b0, 16'd0);
    wr(1'b1, 16'hFFFF);
    pulse_load();
    highs = 0;
    for (int k = 0; k < 65536; k++) begin
      if (k > 0) @(negedge clk);
      if (pwm_out === 1'b1) highs++;
      if (k == 65535) check("R8 low on last tick", pwm_out, 0);
    end
    check("R8 high ticks in 65536 period", highs, 65535);
    @(negedge clk);
    check("R8 high again after wrap", pwm_out, 1);

    // R2: hardware left the staging registers alone
    readback(1'b0, 16'h0000, "R2 period unchanged by hardware");
    readback(1'b1, 16'hFFFF, "R2 width unchanged by hardware");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule